// File: doc/BRIEF.md
# Background Debug Arming and Event Dispatch Controller

This block sits beside a processor's sequencer and settles two questions. First, whether background debug mode is armed at all: the active-low breakpoint pin is passed through a two-flop synchronizer and qualified by a consecutive-low counter while system reset is held. The armed flag takes its value on the last clock of reset and then holds it until the next reset.

Second, what each debug-related event does. Five event sources are weighed in a fixed priority: double bus fault, external breakpoint pin (a synchronized falling edge), internal peripheral breakpoint, background instruction and software breakpoint instruction. Exactly one registered action pulse results. When the block is armed, the first four sources enter debug mode. When it is not armed, each source falls back to its own exception or to a halt. The software breakpoint instruction always requests opcode substitution.

While debug mode is active, a freeze output is held high and every event is ignored until a resume strobe arrives. A halt is left only through reset.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: If the synchronized breakpoint pin is qualified low on the last clock before `rst_n` rises, `dbg_en` reads 1 after release.
- R2: If the pin is high, or not qualified, at reset release, `dbg_en` reads 0.
- R3: `dbg_en` holds its value for as long as `rst_n` stays high, and it is sampled again at every reset release.
- R4: Qualification requires the pin to be low at the synchronizer output for 2 consecutive clocks, or 4 when `alt_seq`=1. With the 2-flop synchronizer, `brk_n` must therefore be low across 4 (or 6) rising edges of reset. One edge fewer leaves the block disarmed.
- R5: When armed and running, a double bus fault, a pin breakpoint, a peripheral breakpoint or a background instruction pulses `act_enter` and raises `freeze`.
- R6: When disarmed, a pin breakpoint or a peripheral breakpoint pulses `act_brkexc`, a background instruction pulses `act_illegal`, and a double bus fault pulses `act_halt`.
- R7: A software breakpoint instruction pulses `act_opsub` whether armed or not, and never raises `freeze`.
- R8: Simultaneous events resolve in the order double bus fault > pin > peripheral breakpoint > background instruction > software breakpoint. At most one action output is high in any cycle.
- R9: `freeze` stays high in debug mode, and all events are ignored there. A `resume` strobe drops `freeze` on the next edge. `resume` outside debug mode has no effect.
- R10: After a halt action, `halted` stays high and all events, including `resume`, are ignored until reset.
- R11: A strobe sampled at one rising edge produces its action pulse from that edge, one cycle wide. A pin falling edge acts on the third rising edge after it. A pin still held low when reset is released produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset; its release latches the armed flag |
| alt_seq | input | 1 | Selects the longer 4-clock qualification for the reset sequence |
| brk_n | input | 1 | Asynchronous active-low breakpoint pin |
| evt_dbf | input | 1 | Double bus fault strobe |
| evt_bgnd | input | 1 | Background instruction decode strobe |
| evt_pbrk | input | 1 | Internal peripheral breakpoint strobe |
| evt_swbrk | input | 1 | Software breakpoint instruction strobe |
| resume | input | 1 | Leave debug mode |
| dbg_en | output | 1 | Debug mode armed |
| freeze | output | 1 | High while in debug mode |
| halted | output | 1 | High after a halt until reset |
| act_enter | output | 1 | Pulse: enter debug mode |
| act_brkexc | output | 1 | Pulse: take breakpoint exception |
| act_illegal | output | 1 | Pulse: take illegal-instruction exception |
| act_halt | output | 1 | Pulse: halt |
| act_opsub | output | 1 | Pulse: opcode substitution / illegal instruction |

## Verification
Several properties are checked on every cycle: the one-hot limit on action pulses, the stability of `dbg_en` out of reset, that `freeze` only rises with an enter pulse, the silence of the action outputs outside the running mode, the permanence of the halt, and that an opcode-substitution pulse is always traced to a software breakpoint strobe. Other behaviours are shown only by the bench's scenarios. These include the exact qualification length at the 3/4 and 5/6 edge boundaries, the armed and disarmed mapping of each source, the priority between specific simultaneous events, the three-edge latency of the pin path, and the absence of a spurious pin event after reset.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_DEBUG = 2'd1,
        MODE_HALT  = 2'd2
    } mode_e;

    // Action vector bit positions
    localparam int NUM_ACT     = 5;
    localparam int ACT_ENTER   = 0;
    localparam int ACT_BRKEXC  = 1;
    localparam int ACT_ILLEGAL = 2;
    localparam int ACT_HALT    = 3;
    localparam int ACT_OPSUB   = 4;

    // Event vector, index 0 is the highest priority
    localparam int NUM_EVT  = 5;
    localparam int EV_DBF   = 0;
    localparam int EV_PIN   = 1;
    localparam int EV_PBRK  = 2;
    localparam int EV_BGND  = 3;
    localparam int EV_SWBRK = 4;

    typedef logic [NUM_ACT-1:0] act_t;
    typedef logic [NUM_EVT-1:0] evt_t;

    // Action index chosen for a given event source and arming state
    function automatic int action_of(input int ev, input logic armed);
        int r;
        case (ev)
            EV_DBF:          r = armed ? ACT_ENTER : ACT_HALT;
            EV_PIN, EV_PBRK: r = armed ? ACT_ENTER : ACT_BRKEXC;
            EV_BGND:         r = armed ? ACT_ENTER : ACT_ILLEGAL;
            default:         r = ACT_OPSUB;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbg_arm_sync.sv
module dbg_arm_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int NORM_CYC    = 2,
    parameter int ALT_CYC     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alt_seq,
    input  logic brk_n,
    output logic armed,
    output logic pin_fall
);
    localparam int MAX_CYC = (ALT_CYC > NORM_CYC) ? ALT_CYC : NORM_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;
        logic [CNT_W-1:0]       low_cnt;
        logic                   armed;
    } arm_st_t;

    arm_st_t st_d, st_q;
    logic    pin_s;
    logic [CNT_W-1:0] need;

    assign pin_s = st_q.chain[SYNC_STAGES-1];
    assign need  = alt_seq ? CNT_W'(ALT_CYC) : CNT_W'(NORM_CYC);

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[SYNC_STAGES-2:0], brk_n};
        st_d.last  = pin_s;
        if (pin_s)
            st_d.low_cnt = '0;
        else if (st_q.low_cnt != CNT_W'(MAX_CYC))
            st_d.low_cnt = st_q.low_cnt + 1'b1;
        // Flag follows the qualifier through reset, frozen afterwards
        if (!rst_n)
            st_d.armed = (st_d.low_cnt >= need);
    end

    // Synchronizer and qualifier run during reset by design
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign armed    = st_q.armed;
    assign pin_fall = st_q.last & ~pin_s;

    // R3
    armed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(st_q.armed));

endmodule

// File: rtl/dbg_event_arb.sv
module dbg_event_arb
    import dbg_ctrl_pkg::*;
(
    input  evt_t evt,
    input  logic armed,
    output act_t act,
    output logic any
);
    always_comb begin
        act = '0;
        any = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (evt[i] && !any) begin
                act[action_of(i, armed)] = 1'b1;
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NORM_CYC    = 2,
    parameter int ALT_CYC     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alt_seq,
    input  logic brk_n,
    input  logic evt_dbf,
    input  logic evt_bgnd,
    input  logic evt_pbrk,
    input  logic evt_swbrk,
    input  logic resume,
    output logic dbg_en,
    output logic freeze,
    output logic halted,
    output logic act_enter,
    output logic act_brkexc,
    output logic act_illegal,
    output logic act_halt,
    output logic act_opsub
);
    typedef struct packed {
        mode_e mode;
        act_t  act;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    armed, pin_fall, any_evt;
    evt_t    evt;
    act_t    arb_act;

    dbg_arm_sync #(
        .SYNC_STAGES(SYNC_STAGES),
        .NORM_CYC   (NORM_CYC),
        .ALT_CYC    (ALT_CYC)
    ) i_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .alt_seq (alt_seq),
        .brk_n   (brk_n),
        .armed   (armed),
        .pin_fall(pin_fall)
    );

    always_comb begin
        evt           = '0;
        evt[EV_DBF]   = evt_dbf;
        evt[EV_PIN]   = pin_fall;
        evt[EV_PBRK]  = evt_pbrk;
        evt[EV_BGND]  = evt_bgnd;
        evt[EV_SWBRK] = evt_swbrk;
    end

    dbg_event_arb i_arb (
        .evt  (evt),
        .armed(armed),
        .act  (arb_act),
        .any  (any_evt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.act = '0;
        if (!rst_n) begin
            st_d.mode = MODE_RUN;
        end else begin
            case (st_q.mode)
                MODE_RUN: begin
                    if (any_evt) begin
                        st_d.act = arb_act;
                        if (arb_act[ACT_ENTER])
                            st_d.mode = MODE_DEBUG;
                        else if (arb_act[ACT_HALT])
                            st_d.mode = MODE_HALT;
                    end
                end
                MODE_DEBUG: begin
                    if (resume)
                        st_d.mode = MODE_RUN;
                end
                default: st_d.mode = MODE_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dbg_en      = armed;
    assign freeze      = (st_q.mode == MODE_DEBUG);
    assign halted      = (st_q.mode == MODE_HALT);
    assign act_enter   = st_q.act[ACT_ENTER];
    assign act_brkexc  = st_q.act[ACT_BRKEXC];
    assign act_illegal = st_q.act[ACT_ILLEGAL];
    assign act_halt    = st_q.act[ACT_HALT];
    assign act_opsub   = st_q.act[ACT_OPSUB];

    // R8
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_enter, act_brkexc, act_illegal, act_halt, act_opsub}));

    // R5
    freeze_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze) |-> act_enter);

    // R9
    quiet_outside_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze || halted) |=> (st_q.act == '0));

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R7
    opsub_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_opsub |-> ($past(evt_swbrk) && !freeze));

endmodule

// File: tb/test_dbg_entry_ctrl.sv
module test_dbg_entry_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0, alt_seq = 1'b0, brk_n = 1'b1;
    logic evt_dbf = 1'b0, evt_bgnd = 1'b0, evt_pbrk = 1'b0, evt_swbrk = 1'b0, resume = 1'b0;
    logic dbg_en, freeze, halted;
    logic act_enter, act_brkexc, act_illegal, act_halt, act_opsub;
    int checks = 0, failures = 0;

    // action encoding {opsub, halt, illegal, brkexc, enter}
    localparam logic [4:0] A_NONE = 5'b00000, A_ENT = 5'b00001, A_BRK = 5'b00010,
                           A_ILL = 5'b00100, A_HLT = 5'b01000, A_OPS = 5'b10000;

    always #5 clk = ~clk;

    dbg_entry_ctrl i_dbg_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .alt_seq(alt_seq), .brk_n(brk_n),
        .evt_dbf(evt_dbf), .evt_bgnd(evt_bgnd), .evt_pbrk(evt_pbrk),
        .evt_swbrk(evt_swbrk), .resume(resume),
        .dbg_en(dbg_en), .freeze(freeze), .halted(halted),
        .act_enter(act_enter), .act_brkexc(act_brkexc), .act_illegal(act_illegal),
        .act_halt(act_halt), .act_opsub(act_opsub)
    );

    function automatic logic [4:0] acts();
        return {act_opsub, act_halt, act_illegal, act_brkexc, act_enter};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", req, got, exp);
        end
    endtask

    // low_edges: rising edges of reset during which brk_n is low before release
    task automatic do_reset(input int low_edges, input logic alt);
        @(negedge clk);
        rst_n = 1'b0; brk_n = 1'b1; alt_seq = alt;
        repeat (6) @(negedge clk);
        if (low_edges > 0) begin
            brk_n = 1'b0;
            repeat (low_edges) @(posedge clk);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic release_pin();
        brk_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // strobe mask {swbrk, bgnd, pbrk, dbf}
    task automatic strobe(input logic [3:0] m, input logic [4:0] exp, input string req);
        {evt_swbrk, evt_bgnd, evt_pbrk, evt_dbf} = m;
        @(negedge clk);
        {evt_swbrk, evt_bgnd, evt_pbrk, evt_dbf} = 4'b0;
        check(req, 8'(acts()), 8'(exp));
        @(negedge clk);
        check({req, " pulse width"}, 8'(acts()), 8'(A_NONE));
    endtask

    task automatic t_reset_state();
        do_reset(0, 1'b0);
        @(negedge clk);
        check("R2 disarmed", 8'(dbg_en), 8'd0);
        check("R2 idle outputs", 8'({freeze, halted, acts()}), 8'd0);
    endtask

    task automatic t_qualify();
        do_reset(10, 1'b0); release_pin();
        check("R1 armed long low", 8'(dbg_en), 8'd1);
        do_reset(4, 1'b0); release_pin();
        check("R4 normal 4 edges", 8'(dbg_en), 8'd1);
        do_reset(3, 1'b0); release_pin();
        check("R4 normal 3 edges", 8'(dbg_en), 8'd0);
        do_reset(6, 1'b1); release_pin();
        check("R4 alt 6 edges", 8'(dbg_en), 8'd1);
        do_reset(5, 1'b1); release_pin();
        check("R4 alt 5 edges", 8'(dbg_en), 8'd0);
    endtask

    task automatic t_no_spurious();
        do_reset(10, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R11 no event from held pin", 8'(acts()), 8'(A_NONE));
        end
        release_pin();
    endtask

    task automatic t_pin(input logic [4:0] exp, input string req);
        brk_n = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check("R11 pin latency", 8'(acts()), 8'(A_NONE));
        end
        @(negedge clk);
        check(req, 8'(acts()), 8'(exp));
        release_pin();
    endtask

    task automatic t_disarmed_map();
        do_reset(0, 1'b0);
        @(negedge clk);
        strobe(4'b0100, A_ILL, "R6 bgnd disarmed");
        strobe(4'b0010, A_BRK, "R6 pbrk disarmed");
        strobe(4'b1000, A_OPS, "R7 swbrk disarmed");
        t_pin(A_BRK, "R6 pin disarmed");
        strobe(4'b0110, A_BRK, "R8 pbrk over bgnd");
        strobe(4'b1100, A_ILL, "R8 bgnd over swbrk");
        // pin edge together with background instruction
        brk_n = 1'b0;
        repeat (2) @(negedge clk);
        evt_bgnd = 1'b1;
        @(negedge clk);
        evt_bgnd = 1'b0;
        check("R8 pin over bgnd", 8'(acts()), 8'(A_BRK));
        release_pin();
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        check("R9 resume in run ignored", 8'({freeze, halted, acts()}), 8'd0);
        strobe(4'b0101, A_HLT, "R8 dbf over bgnd");
        check("R10 halted", 8'(halted), 8'd1);
        strobe(4'b1110, A_NONE, "R10 events ignored");
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        check("R10 resume no effect", 8'(halted), 8'd1);
        do_reset(0, 1'b0);
        @(negedge clk);
        check("R10 reset clears halt", 8'(halted), 8'd0);
    endtask

    task automatic enter_and_resume(input logic [3:0] m, input string req);
        strobe(m, A_ENT, req);
        check({req, " freeze"}, 8'(freeze), 8'd1);
        strobe(4'b1111, A_NONE, "R9 ignored in debug");
        check("R9 freeze held", 8'(freeze), 8'd1);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        check("R9 resume clears freeze", 8'(freeze), 8'd0);
    endtask

    task automatic t_armed_map();
        do_reset(10, 1'b0); release_pin();
        enter_and_resume(4'b0001, "R5 dbf armed");
        enter_and_resume(4'b0010, "R5 pbrk armed");
        enter_and_resume(4'b0100, "R5 bgnd armed");
        t_pin(A_ENT, "R5 pin armed");
        check("R5 pin freeze", 8'(freeze), 8'd1);
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        strobe(4'b1000, A_OPS, "R7 swbrk armed");
        check("R7 no freeze", 8'(freeze), 8'd0);
        enter_and_resume(4'b1111, "R8 all events armed");
        check("R3 flag held", 8'(dbg_en), 8'd1);
        do_reset(0, 1'b0);
        @(negedge clk);
        check("R3 resampled", 8'(dbg_en), 8'd0);
    endtask

    initial begin
        t_reset_state();
        t_qualify();
        t_no_spurious();
        t_disarmed_map();
        t_armed_map();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule